// File: doc/BRIEF.md
# Real-time clock time, alarm and interrupt register bank

This block is the register side of a real-time clock. It keeps a seconds count that moves forward on a one-second strobe from an external divider. It lets software load a new time, which takes effect at the next second boundary. It compares the count against an alarm value and raises a seconds event and an alarm event. Both events go through a sticky status register that is cleared by writing a 1, and through an enable set that has separate set and clear registers. Their combination drives a single interrupt request line.

Software reaches it through a simple single-cycle 32-bit bus: a write strobe with address and data, and a read path that returns data in the same cycle. The block also holds the calibration word and two control bits, for the oscillator and for the battery switch. Their outputs go to logic outside the block. Between strobes, a cycle counter shows how far into the current second the block is.

Top module: `rtc_regbank`

## Requirements
- R1: After reset, the current time, the status, the enables, the control bits, the calibration word and the interrupt request are all zero.
- R2: Each cycle with `sec_tick` high and no pending load raises the current time (offset 0x10) by one. From 0xFFFFFFFF it wraps to 0.
- R3: A write to offset 0x00 shows at once on the readback at offset 0x04. The current time keeps its old value until the next strobe, which loads the written value in place of an increment.
- R4: Status bit 0 sets on every strobe. A write to offset 0x00 clears it, so it reads 0 until the load has happened.
- R5: The status register (offset 0x20, bit 0 seconds, bit 1 alarm) clears each bit written with 1 and ignores bits written with 0. A clear and a new event in the same cycle leave the bit set.
- R6: The alarm word (offset 0x18) reads back as written. Status bit 1 sets on a strobe after which the current time equals the alarm word, whether by increment or by load. Writing an alarm equal to the present time does not set it.
- R7: Writing 1s to offset 0x28 sets enable bits and writing 1s to offset 0x2C clears them. Bits written with 0 are unchanged. Offset 0x24 reads the enable bits in positions 1:0.
- R8: `irq` is high exactly when some status bit and its enable bit are both set.
- R9: At offset 0x40, only bit 24 (oscillator enable, `osc_en`) and bit 31 (battery switch enable, `batt_sw_en`) are stored. All other bits read 0.
- R10: The low 21 bits written to offset 0x08 are stored. They drive `calib_word` and read back at offset 0x0C.
- R11: Offsets outside the map read 0 and writes to them change nothing. The write-only offsets 0x00, 0x08, 0x28 and 0x2C read 0.
- R12: Offset 0x14 reads the number of clock cycles since the last strobe. It is zeroed by the strobe and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as address |
| irq | output | 1 | Interrupt request |
| osc_en | output | 1 | Stored oscillator enable bit |
| batt_sw_en | output | 1 | Stored battery switch enable bit |
| calib_word | output | 21 | Stored calibration value |

## Verification
The time counter is driven three ways: by plain strobes, by strobes after a set-time write, and across the all-ones wrap. These separate an increment from a load and show whether a load is deferred or immediate. The alarm is reached once by counting up and once through a load. A separate write of an alarm equal to the present time separates "becomes equal" from "is equal". A status clear issued in the same cycle as a strobe shows whether the set or the clear has priority. The enable and mask registers are used with status bits that are set but not enabled, to tell the gating of `irq` apart from the status itself.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int OFS_SET_WR = 'h00;
  localparam int OFS_SET_RD = 'h04;
  localparam int OFS_CAL_WR = 'h08;
  localparam int OFS_CAL_RD = 'h0C;
  localparam int OFS_NOW    = 'h10;
  localparam int OFS_SUB    = 'h14;
  localparam int OFS_ALM    = 'h18;
  localparam int OFS_STAT   = 'h20;
  localparam int OFS_MASK   = 'h24;
  localparam int OFS_IEN    = 'h28;
  localparam int OFS_IDIS   = 'h2C;
  localparam int OFS_CTRL   = 'h40;

  localparam int IRQ_SEC = 0;
  localparam int IRQ_ALM = 1;
  localparam int NUM_IRQ = 2;

  localparam int CTRL_OSC_BIT  = 24;
  localparam int CTRL_BATT_BIT = 31;

  typedef struct packed {
    logic set_time;
    logic calib;
    logic alarm;
    logic status;
    logic ien;
    logic idis;
    logic ctrl;
  } wr_sel_t;
endpackage

// File: rtl/rtc_addr_dec.sv
module rtc_addr_dec
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output wr_sel_t           sel
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    sel.set_time = wr && hit(addr, OFS_SET_WR);
    sel.calib    = wr && hit(addr, OFS_CAL_WR);
    sel.alarm    = wr && hit(addr, OFS_ALM);
    sel.status   = wr && hit(addr, OFS_STAT);
    sel.ien      = wr && hit(addr, OFS_IEN);
    sel.idis     = wr && hit(addr, OFS_IDIS);
    sel.ctrl     = wr && hit(addr, OFS_CTRL);
  end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
  parameter int TIME_W = 32,
  parameter int SUB_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              set_wr,
  input  logic [TIME_W-1:0] set_data,
  input  logic [TIME_W-1:0] alarm_val,
  output logic [TIME_W-1:0] cur_time,
  output logic [TIME_W-1:0] set_val,
  output logic              load_pending,
  output logic [SUB_W-1:0]  sub_count,
  output logic              alarm_evt
);
  function automatic logic [TIME_W-1:0] next_time(input logic [TIME_W-1:0] cur,
                                                  input logic pend,
                                                  input logic [TIME_W-1:0] setv);
    return pend ? setv : cur + TIME_W'(1);
  endfunction

  function automatic logic [SUB_W-1:0] sat_inc(input logic [SUB_W-1:0] v);
    return (&v) ? v : v + SUB_W'(1);
  endfunction

  logic [TIME_W-1:0] time_nxt;
  assign time_nxt  = next_time(cur_time, load_pending, set_val);
  assign alarm_evt = sec_tick && (time_nxt == alarm_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_time     <= '0;
      set_val      <= '0;
      load_pending <= 1'b0;
      sub_count    <= '0;
    end else begin
      if (sec_tick) cur_time <= time_nxt;
      if (set_wr) begin
        set_val      <= set_data;
        load_pending <= 1'b1;
      end else if (sec_tick) begin
        load_pending <= 1'b0;
      end
      sub_count <= sec_tick ? '0 : sat_inc(sub_count);
    end
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] auto_clr,
  input  logic         stat_wr,
  input  logic         en_wr,
  input  logic         dis_wr,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] status,
  output logic [N-1:0] enable,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s_q, e_q, clr;
    assign clr = (stat_wr && wr_bits[i]) || auto_clr[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= 1'b0;
        e_q <= 1'b0;
      end else begin
        if (evt[i])   s_q <= 1'b1;
        else if (clr) s_q <= 1'b0;
        if (en_wr && wr_bits[i])       e_q <= 1'b1;
        else if (dis_wr && wr_bits[i]) e_q <= 1'b0;
      end
    end
    assign status[i] = s_q;
    assign enable[i] = e_q;
  end

  assign irq = |(status & enable);
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CAL_W  = 21,
  parameter int SUB_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              osc_en,
  output logic              batt_sw_en,
  output logic [CAL_W-1:0]  calib_word
);
  localparam int TIME_W = DATA_W;

  wr_sel_t            sel;
  logic [TIME_W-1:0]  cur_time, set_val, alarm_q;
  logic               load_pending, alarm_evt;
  logic [SUB_W-1:0]   sub_count;
  logic [NUM_IRQ-1:0] evt, auto_clr, status, enable;

  rtc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .wr(bus_wr), .addr(bus_addr), .sel(sel)
  );

  rtc_time_core #(.TIME_W(TIME_W), .SUB_W(SUB_W)) u_time (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .set_wr(sel.set_time), .set_data(bus_wdata), .alarm_val(alarm_q),
    .cur_time(cur_time), .set_val(set_val), .load_pending(load_pending),
    .sub_count(sub_count), .alarm_evt(alarm_evt)
  );

  always_comb begin
    evt               = '0;
    evt[IRQ_SEC]      = sec_tick;
    evt[IRQ_ALM]      = alarm_evt;
    auto_clr          = '0;
    auto_clr[IRQ_SEC] = sel.set_time;
  end

  rtc_irq_ctrl #(.N(NUM_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .auto_clr(auto_clr),
    .stat_wr(sel.status), .en_wr(sel.ien), .dis_wr(sel.idis),
    .wr_bits(bus_wdata[NUM_IRQ-1:0]),
    .status(status), .enable(enable), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q    <= '0;
      calib_word <= '0;
      osc_en     <= 1'b0;
      batt_sw_en <= 1'b0;
    end else begin
      if (sel.alarm) alarm_q    <= bus_wdata;
      if (sel.calib) calib_word <= bus_wdata[CAL_W-1:0];
      if (sel.ctrl) begin
        osc_en     <= bus_wdata[CTRL_OSC_BIT];
        batt_sw_en <= bus_wdata[CTRL_BATT_BIT];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_SET_RD): bus_rdata = set_val;
      ADDR_W'(OFS_CAL_RD): bus_rdata = DATA_W'(calib_word);
      ADDR_W'(OFS_NOW):    bus_rdata = cur_time;
      ADDR_W'(OFS_SUB):    bus_rdata = DATA_W'(sub_count);
      ADDR_W'(OFS_ALM):    bus_rdata = alarm_q;
      ADDR_W'(OFS_STAT):   bus_rdata = DATA_W'(status);
      ADDR_W'(OFS_MASK):   bus_rdata = DATA_W'(enable);
      ADDR_W'(OFS_CTRL): begin
        bus_rdata[CTRL_OSC_BIT]  = osc_en;
        bus_rdata[CTRL_BATT_BIT] = batt_sw_en;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk #(
  parameter int TIME_W = 32,
  parameter int N      = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic              load_pending,
  input logic [TIME_W-1:0] set_val,
  input logic [TIME_W-1:0] cur_time,
  input logic              alarm_evt,
  input logic [N-1:0]      status,
  input logic [N-1:0]      enable,
  input logic              irq
);
  // R2
  tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && !load_pending |=> cur_time == $past(cur_time) + TIME_W'(1));

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && load_pending |=> cur_time == $past(set_val));

  // R3
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(cur_time));

  // R4
  sec_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> status[0]);

  // R6
  alarm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> status[1]);

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|status));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|enable) |-> !irq);
endmodule

bind rtc_regbank rtc_regbank_chk #(.TIME_W(TIME_W), .N(rtc_pkg::NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .load_pending(load_pending),
  .set_val(set_val), .cur_time(cur_time), .alarm_evt(alarm_evt),
  .status(status), .enable(enable), .irq(irq)
);

// File: tb/sim_rtc_regbank.sv
module sim_rtc_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, osc_en, batt_sw_en;
  logic [20:0] calib_word;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  rtc_regbank u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .osc_en(osc_en), .batt_sw_en(batt_sw_en), .calib_word(calib_word)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h10, d); chk("R1 time", d, 0);
    rd(8'h20, d); chk("R1 status", d, 0);
    rd(8'h24, d); chk("R1 mask", d, 0);
    rd(8'h40, d); chk("R1 ctrl", d, 0);
    rd(8'h0C, d); chk("R1 calib", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    tick(); tick(); tick();
    rd(8'h10, d); chk("R2 count", d, 3);
    rd(8'h20, d); chk("R4 sec flag", d & 1, 1);
  endtask

  task automatic t_set();
    logic [31:0] d;
    wr(8'h00, 100);
    rd(8'h04, d); chk("R3 readback", d, 100);
    rd(8'h10, d); chk("R3 deferred", d, 3);
    rd(8'h20, d); chk("R4 cleared by set", d & 1, 0);
    tick();
    rd(8'h10, d); chk("R3 loaded", d, 100);
    rd(8'h20, d); chk("R4 set after load", d & 1, 1);
    tick();
    rd(8'h10, d); chk("R2 after load", d, 101);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(8'h20, 0);
    rd(8'h20, d); chk("R5 zero write", d & 1, 1);
    wr(8'h20, 1);
    rd(8'h20, d); chk("R5 clear", d & 1, 0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 1; sec_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; sec_tick = 1'b0;
    rd(8'h20, d); chk("R5 set wins", d & 1, 1);
  endtask

  task automatic t_alarm();
    logic [31:0] d;
    wr(8'h00, 200); tick();
    wr(8'h20, 3);
    wr(8'h18, 200);
    rd(8'h20, d); chk("R6 equal write no flag", d & 2, 0);
    wr(8'h18, 202);
    rd(8'h18, d); chk("R6 alarm readback", d, 202);
    tick();
    rd(8'h20, d); chk("R6 not yet", d & 2, 0);
    tick();
    rd(8'h20, d); chk("R6 match by count", d & 2, 2);
    wr(8'h20, 2);
    tick();
    rd(8'h20, d); chk("R6 no rematch", d & 2, 0);
    wr(8'h18, 500); wr(8'h00, 500); tick();
    rd(8'h20, d); chk("R6 match by load", d & 2, 2);
    wr(8'h20, 3);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(8'h28, 2);
    rd(8'h24, d); chk("R7 enable alarm", d, 2);
    tick();
    chk("R8 unenabled status", {31'b0, irq}, 0);
    wr(8'h28, 1);
    rd(8'h24, d); chk("R7 enable sec", d, 3);
    chk("R8 irq on", {31'b0, irq}, 1);
    wr(8'h2C, 1);
    rd(8'h24, d); chk("R7 disable sec", d, 2);
    chk("R8 irq off", {31'b0, irq}, 0);
    wr(8'h28, 1); wr(8'h20, 1);
    chk("R8 cleared status", {31'b0, irq}, 0);
    wr(8'h2C, 3);
    rd(8'h24, d); chk("R7 all off", d, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF); tick();
    rd(8'h10, d); chk("R2 max", d, 32'hFFFF_FFFF);
    tick();
    rd(8'h10, d); chk("R2 wrap", d, 0);
  endtask

  task automatic t_ctrl_cal();
    logic [31:0] d;
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, d); chk("R9 ctrl bits", d, 32'h8100_0000);
    chk("R9 outputs", {30'b0, osc_en, batt_sw_en}, 3);
    wr(8'h40, 32'h0100_0000);
    chk("R9 osc only", {30'b0, osc_en, batt_sw_en}, 2);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h0C, d); chk("R10 calib readback", d, 32'h001F_FFFF);
    chk("R10 calib out", {11'b0, calib_word}, 32'h001F_FFFF);
    rd(8'h08, d); chk("R11 write-only calib", d, 0);
    rd(8'h00, d); chk("R11 write-only set", d, 0);
    rd(8'h28, d); chk("R11 write-only en", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h30, 32'hDEAD_BEEF);
    wr(8'h1C, 32'h1234_5678);
    rd(8'h30, d); chk("R11 unmapped read", d, 0);
    rd(8'h1C, d); chk("R11 unmapped read 1C", d, 0);
    rd(8'h18, d); chk("R11 alarm untouched", d, 500);
    rd(8'h40, d); chk("R11 ctrl untouched", d, 32'h0100_0000);
    rd(8'h10, d); chk("R11 time untouched", d, 0);
    rd(8'h24, d); chk("R11 mask untouched", d, 0);
  endtask

  task automatic t_sub();
    logic [31:0] d;
    tick();
    rd(8'h14, d); chk("R12 zeroed", d, 0);
    repeat (5) @(negedge clk);
    rd(8'h14, d); chk("R12 count", d, 5);
    repeat (70000) @(negedge clk);
    rd(8'h14, d); chk("R12 saturate", d, 32'h0000_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_set();
    t_w1c();
    t_alarm();
    t_irq();
    t_wrap();
    t_ctrl_cal();
    t_unmapped();
    t_sub();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule